// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This is a purely combinational helper for a 32-bit integer datapath. From two operands `A` and `B`, a carry-in and a 2-bit operation select, it forms one 32-bit result word and a carry-out bit. There are four operations:

- **Signed compare.**
- **Unsigned compare.**
- **Byte-lane search.** It reports the first byte position, counted from the most significant end, at which the two words hold the same byte.
- **Carry-out.** It gives the carry of an add-with-carry of the two operands.

The compare operations return the difference `B - A`. Its top bit is replaced by a true less-than indicator, so a single bit test on the result tells whether `B` is below `A`. The lower bits still carry the difference.

The unit has no state. Any register stage, flag storage or instruction decode around it belongs to the surrounding pipeline.

Top module: `cmp_bytematch_unit`

## Requirements
- R1: For operation code 2'b00 (signed compare), result bits 30:0 equal bits 30:0 of `B - A` computed modulo 2^32.
- R2: For operation code 2'b00, result bit 31 is 1 exactly when `B` is less than `A` as two's-complement numbers.
- R3: For operation code 2'b01 (unsigned compare), result bit 31 is 1 exactly when `B` is less than `A` as unsigned numbers, and bits 30:0 equal bits 30:0 of `B - A`.
- R4: When bit 31 of `A` equals bit 31 of `B`, both compare codes return the full 32-bit value `B - A` modulo 2^32.
- R5: For operation code 2'b10 (byte find), byte lanes are examined in the order bits 31:24, 23:16, 15:8, 7:0. The result is the 1-based position (1 to 4) of the first lane in that order where `A` and `B` hold the same byte.
- R6: For operation code 2'b10, the result is 0 when no lane of `A` equals the same lane of `B`. In all byte-find cases, bits 31:3 of the result are 0.
- R7: For operation code 2'b11 (carry), result bit 0 and `cout` both equal the carry out of the 32-bit sum `A + B + cin`, and result bits 31:1 are 0.
- R8: `cout` is 0 whenever the operation code is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| cin | input | 1 | Carry-in for the carry operation |
| op_sel | input | 2 | Operation: 00 signed cmp, 01 unsigned cmp, 10 byte find, 11 carry |
| result | output | 32 | Result word |
| cout | output | 1 | Carry-out; meaningful only for operation code 11 |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and 8-bit lanes, which gives four byte lanes.

- **Compare.** Every pairing of the boundary operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF is applied, so the top-bit replacement is exercised on both sides of the sign and magnitude boundaries.
- **Byte find.** Matches are placed in each lane singly and several at once, which shows the search priority.
- **Carry.** The all-ones operand with carry-in reaches the special carry case.
- **Random operands.** These add coverage beyond the directed cases.

// File: rtl/cbm_pkg.sv
// Package: shared operation encoding for the compare and byte-match unit.
// Assumes a 2-bit operation select port on the top module.
package cbm_pkg;
    typedef enum logic [1:0] {
        OP_SCMP  = 2'b00,
        OP_UCMP  = 2'b01,
        OP_FIND  = 2'b10,
        OP_CARRY = 2'b11
    } cbm_op_e;
endpackage

// File: rtl/cbm_compare.sv
// Module: cbm_compare
// Forms B - A as B + ~A + 1 and replaces the top bit when the operand
// top bits differ: with B's top bit for signed mode, A's for unsigned.
// The result's top bit is then a true B < A indicator.
// Assumes DATA_W >= 2. Purely combinational.
module cbm_compare #(
    parameter int DATA_W      = 32,
    parameter bit SIGNED_MODE = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] diff_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] raw_diff;
    logic              sign_differs;
    logic              fix_bit;

    // Raw two's-complement difference B - A.
    always_comb raw_diff = b + ~a + DATA_W'(1);

    // Detect operands whose top bits disagree.
    always_comb sign_differs = a[MSB] ^ b[MSB];

    // The variant picks the top-bit source used when signs differ.
    generate
        if (SIGNED_MODE) begin : g_signed
            always_comb fix_bit = b[MSB];
        end else begin : g_unsigned
            always_comb fix_bit = a[MSB];
        end
    endgenerate

    // Merge the replacement top bit with the raw low bits.
    always_comb begin
        diff_out = raw_diff;
        if (sign_differs) begin
            diff_out[MSB] = fix_bit;
        end
    end
endmodule

// File: rtl/cbm_lane_find.sv
// Module: cbm_lane_find
// Compares equal-position lanes of two words and reports the 1-based
// index of the first equal lane, counted from the most significant
// lane. Reports 0 when no lane is equal.
// Assumes DATA_W is a multiple of LANE_W. Purely combinational.
module cbm_lane_find #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W,
    localparam int IDX_W  = $clog2(NLANES + 1)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [IDX_W-1:0]  lane_idx
);
    logic [NLANES-1:0] lane_eq;

    // One equality comparator per lane; index 0 is the top lane.
    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            localparam int HI = DATA_W - 1 - g * LANE_W;
            always_comb lane_eq[g] = (a[HI -: LANE_W] == b[HI -: LANE_W]);
        end
    endgenerate

    // Priority pick: the lowest lane number (most significant lane) wins.
    always_comb begin
        lane_idx = '0;
        for (int i = NLANES - 1; i >= 0; i--) begin
            if (lane_eq[i]) begin
                lane_idx = IDX_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/cbm_carry.sv
// Module: cbm_carry
// Carry-out of A + B + cin without a wide adder. The carry is set when
// B is all ones with cin set, or when the headroom (all-ones - A) is
// below B + cin. Purely combinational.
module cbm_carry #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic              carry
);
    logic [DATA_W-1:0] headroom;
    logic [DATA_W-1:0] b_plus_c;
    logic              b_full;

    // Remaining space above A, and the addend B + cin.
    always_comb begin
        headroom = ~a;
        b_plus_c = b + DATA_W'(cin);
        b_full   = &b;
    end

    // Special case first, then the headroom comparison.
    always_comb carry = (b_full && cin) || (headroom < b_plus_c);
endmodule

// File: rtl/cmp_bytematch_unit.sv
// Module: cmp_bytematch_unit (top)
// Integer compare (signed and unsigned), lane-match search and carry-out
// generation, selected by op_sel. Purely combinational; any output
// register stage belongs to the surrounding pipeline.
// Assumes DATA_W is a multiple of LANE_W and wide enough for the index.
module cmp_bytematch_unit
    import cbm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              cin,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic              cout
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int IDX_W  = $clog2(NLANES + 1);

    logic [DATA_W-1:0] scmp_res;
    logic [DATA_W-1:0] ucmp_res;
    logic [IDX_W-1:0]  find_idx;
    logic              carry_bit;
    cbm_op_e           op;

    cbm_compare #(.DATA_W(DATA_W), .SIGNED_MODE(1'b1)) u_scmp (
        .a(op_a), .b(op_b), .diff_out(scmp_res)
    );

    cbm_compare #(.DATA_W(DATA_W), .SIGNED_MODE(1'b0)) u_ucmp (
        .a(op_a), .b(op_b), .diff_out(ucmp_res)
    );

    cbm_lane_find #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_find (
        .a(op_a), .b(op_b), .lane_idx(find_idx)
    );

    cbm_carry #(.DATA_W(DATA_W)) u_carry (
        .a(op_a), .b(op_b), .cin(cin), .carry(carry_bit)
    );

    // Cast the raw select into the shared encoding.
    always_comb op = cbm_op_e'(op_sel);

    // Result select; the index and the carry are zero-extended.
    always_comb begin
        unique case (op)
            OP_SCMP:  result = scmp_res;
            OP_UCMP:  result = ucmp_res;
            OP_FIND:  result = {{(DATA_W - IDX_W){1'b0}}, find_idx};
            OP_CARRY: result = {{(DATA_W - 1){1'b0}}, carry_bit};
            default:  result = '0;
        endcase
    end

    // Carry-out is only driven for the carry operation.
    always_comb cout = (op == OP_CARRY) ? carry_bit : 1'b0;
endmodule

// File: rtl/cbm_checker.sv
// Module: cbm_checker
// Property checks for cmp_bytematch_unit, attached by bind below.
// The block has no clock, so the checks are immediate and evaluated
// whenever the ports settle.
module cbm_checker #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              cin,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] result,
    input logic              cout
);
    localparam int NLANES = DATA_W / LANE_W;

    logic [DATA_W:0] wide_sum;
    logic [NLANES-1:0] eq_vec;

    // Reference lane equality vector; index 0 is the top lane.
    always_comb begin
        for (int i = 0; i < NLANES; i++) begin
            eq_vec[i] = (op_a[DATA_W-1-i*LANE_W -: LANE_W] ==
                         op_b[DATA_W-1-i*LANE_W -: LANE_W]);
        end
    end

    // Reference wide sum for the carry check.
    always_comb wide_sum = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};

    // Checks across the result and carry ports.
    always_comb begin
        if (op_sel == 2'b00) begin
            AST_SCMP_LT: assert (result[DATA_W-1] == ($signed(op_b) < $signed(op_a)))
                else $error("signed less-than bit wrong"); // R2
        end
        if (op_sel == 2'b01) begin
            AST_UCMP_LT: assert (result[DATA_W-1] == (op_b < op_a))
                else $error("unsigned less-than bit wrong"); // R3
        end
        if (op_sel == 2'b10 && result == '0) begin
            AST_FIND_NONE: assert (eq_vec == '0)
                else $error("find reported no match but a lane matches"); // R6
        end
        if (op_sel == 2'b10 && result != '0 && result <= DATA_W'(NLANES)) begin
            AST_FIND_HIT: assert (eq_vec[result - 1] && ((eq_vec & ((NLANES'(1) << (result - 1)) - NLANES'(1))) == '0))
                else $error("find index does not name the first match"); // R5
        end
        if (op_sel == 2'b11) begin
            AST_CARRY_OUT: assert (cout == wide_sum[DATA_W] && result == DATA_W'(wide_sum[DATA_W]))
                else $error("carry result wrong"); // R7
        end
        if (op_sel != 2'b11) begin
            AST_COUT_IDLE: assert (!cout)
                else $error("carry-out active outside carry op"); // R8
        end
    end
endmodule

bind cmp_bytematch_unit cbm_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cbm_chk (
    .op_a(op_a), .op_b(op_b), .cin(cin), .op_sel(op_sel),
    .result(result), .cout(cout)
);

// File: tb/cmp_bytematch_unit_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for cmp_bytematch_unit, one task per scenario.
module cmp_bytematch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        cin = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] result;
    logic        cout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_bytematch_unit #(.DATA_W(32), .LANE_W(8)) dut_i (
        .op_a(op_a), .op_b(op_b), .cin(cin), .op_sel(op_sel),
        .result(result), .cout(cout)
    );

    // Record one check and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h op=%b act=%h exp=%h", req, op_a, op_b, op_sel, act, exp);
        end
    endtask

    // Drive inputs away from the clock edge, then let them settle.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c, input logic [1:0] op);
        @(negedge clk);
        op_a = a; op_b = b; cin = c; op_sel = op;
        #1;
    endtask

    // Reference first-match lane index counted from the top byte.
    function automatic logic [31:0] ref_find(input logic [31:0] a, input logic [31:0] b);
        for (int i = 0; i < 4; i++) begin
            if (a[31-8*i -: 8] == b[31-8*i -: 8]) return 32'(i + 1);
        end
        return 32'd0;
    endfunction

    // Check both compare codes for one operand pair.
    task automatic cmp_pair(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        d = b - a;
        apply(a, b, 1'b0, 2'b00);
        chk("R1", {1'b0, result[30:0]}, {1'b0, d[30:0]});
        chk("R2", {31'd0, result[31]}, {31'd0, $signed(b) < $signed(a)});
        chk("R8", {31'd0, cout}, 32'd0);
        if (a[31] == b[31]) chk("R4 signed", result, d);
        apply(a, b, 1'b0, 2'b01);
        chk("R3 msb", {31'd0, result[31]}, {31'd0, b < a});
        chk("R3 low", {1'b0, result[30:0]}, {1'b0, d[30:0]});
        if (a[31] == b[31]) chk("R4 unsigned", result, d);
    endtask

    task automatic t_reset_state();
        apply('0, '0, 1'b0, 2'b00);
        chk("R4 zero operands", result, 32'd0);
        chk("R8 zero operands", {31'd0, cout}, 32'd0);
    endtask

    task automatic t_compare_bounds();
        logic [31:0] bv [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                cmp_pair(bv[i], bv[j]);
        cmp_pair(32'd5, 32'd3);
        cmp_pair(32'd3, 32'd5);
    endtask

    task automatic t_find();
        logic [31:0] av [6] = '{32'h11223344, 32'h11223344, 32'h11223344,
                                32'h11223344, 32'h11223344, 32'hAABBCCDD};
        logic [31:0] bv [6] = '{32'h11000000, 32'h00220000, 32'h00003300,
                                32'h00000044, 32'h00223344, 32'h00000000};
        logic [31:0] ev [6] = '{32'd1, 32'd2, 32'd3, 32'd4, 32'd2, 32'd0};
        for (int k = 0; k < 6; k++) begin
            apply(av[k], bv[k], 1'b1, 2'b10);
            if (ev[k] == 0) chk("R6 no match", result, 32'd0);
            else chk("R5 lane index", result, ev[k]);
            chk("R8 find", {31'd0, cout}, 32'd0);
        end
        apply(32'hCAFEBABE, 32'hCAFEBABE, 1'b0, 2'b10);
        chk("R5 all equal picks top", result, 32'd1);
    endtask

    task automatic t_carry();
        logic [31:0] av [5] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF};
        logic [31:0] bv [5] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h80000000, 32'h80000000};
        logic [32:0] s;
        for (int k = 0; k < 5; k++) begin
            for (int c = 0; c < 2; c++) begin
                apply(av[k], bv[k], c[0], 2'b11);
                s = {1'b0, av[k]} + {1'b0, bv[k]} + 33'(c);
                chk("R7 result", result, {31'd0, s[32]});
                chk("R7 cout", {31'd0, cout}, {31'd0, s[32]});
            end
        end
    endtask

    task automatic t_random();
        logic [31:0] a;
        logic [31:0] b;
        logic [32:0] s;
        for (int k = 0; k < 200; k++) begin
            a = $urandom; b = $urandom;
            if (k % 4 == 0) b[15:8] = a[15:8];
            cmp_pair(a, b);
            apply(a, b, 1'b0, 2'b10);
            chk("R5 R6 random find", result, ref_find(a, b));
            apply(a, b, k[0], 2'b11);
            s = {1'b0, a} + {1'b0, b} + 33'(k[0]);
            chk("R7 random carry", {31'd0, cout}, {31'd0, s[32]});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_compare_bounds();
        t_find();
        t_carry();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule